// File: doc/BRIEF.md
# Serial EEPROM Write-Protect and Status Controller

This block keeps the status state of a serial EEPROM slave and decides whether a write may proceed. The command decoder in front of it sends single-cycle strobes: set-enable, clear-enable, status write with its data byte, and array write commit with the target address. The block also watches the active-low write-protect pin. It returns the status byte for readback, a flag that says whether a write to the presented address would be accepted, a busy flag, and a flag that says whether array reads may be serviced.

An accepted array commit or status write starts a self-timed internal write cycle. The cycle lasts `CYC_LEN` system clocks. While the cycle runs, the block reports itself busy and takes no new command. When the cycle ends, the enable latch clears. A status write changes the protect-enable bit and the block-protect field only at the end of its cycle.

The control is a three-state machine. The states are IDLE, ARRAY_PROG and STATUS_PROG. An accepted commit moves IDLE to ARRAY_PROG. An accepted status write moves IDLE to STATUS_PROG. In either programming state, the timer's done pulse returns the machine to IDLE. No other transition exists.

Top module: `wpsr_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00 and both busy and the write-allowed flag are low.
- R2: The status byte holds the enable latch at bit 1. A set-enable strobe in IDLE sets this bit on the next cycle. A clear-enable strobe in IDLE clears it. Neither the protect-enable bit nor the pin affects these two commands.
- R3: A commit in IDLE is accepted when the enable latch is 1 and the address is unprotected. busy_o and status bit 0 then go high on the next cycle and stay high for exactly CYC_LEN cycles. After that, the enable latch reads 0.
- R4: A commit is dropped when the enable latch is 0 or the address is protected. A dropped commit starts no cycle and leaves the status byte unchanged.
- R5: The block-protect field sits at status bits 3:2. Its codes are: 00 protects nothing; 01 protects addresses whose top two bits are 11; 10 protects addresses whose top bit is 1; 11 protects all addresses. wr_allowed_o is high only when the enable latch is 1, the block is not busy, and commit_addr is unprotected.
- R6: A status write in IDLE is accepted when the enable latch is 1 and the pin lock (R7) is not in force. It runs a cycle of CYC_LEN clocks. At the end, status bit 7 takes data bit 7 and bits 3:2 take data bits 3:2. The enable latch clears. Data bits 1:0 never reach the latch or the busy bit.
- R7: When status bit 7 is 1 and wp_n is 0, a status write is refused: no cycle starts and the status byte is unchanged. When status bit 7 is 0, wp_n has no effect.
- R8: wp_n falling after a status write has been accepted does not abort the cycle. The new bits are still applied.
- R9: While busy, every command strobe is ignored, status bits 7:1 hold steady, and array_rd_ok_o is low. In IDLE, array_rd_ok_o is high.
- R10: Status bits 6:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Set-enable command strobe |
| cmd_wrdi | input | 1 | Clear-enable command strobe |
| cmd_wrsr | input | 1 | Status write command strobe |
| wrsr_data | input | 8 | Data byte for the status write |
| cmd_commit | input | 1 | Array write commit strobe |
| commit_addr | input | ADDR_W | Target array address |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte: {protect-enable, 000, block-protect[1:0], enable latch, in-progress} |
| wr_allowed_o | output | 1 | A write to commit_addr would be accepted now |
| busy_o | output | 1 | Self-timed write cycle running |
| array_rd_ok_o | output | 1 | Array reads may be serviced |

## Verification
The assertions assume that the decoder raises at most one command strobe per cycle, and that each strobe lasts a single clock. Several checks depend on this assumption. Two examples: the check that a blocked commit leaves the block idle, and the check that a locked status write changes nothing. Both would be wrong if a second, accepted command arrived in the same cycle. The bench drives every command through one task that raises exactly one strobe for one cycle. It changes wp_n and commit_addr only on falling edges, so every input is steady at each rising edge.

// File: rtl/wpsr_pkg.sv
package wpsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ARRAY_PROG  = 2'd1,
        ST_STATUS_PROG = 2'd2
    } wp_state_t;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_t;

    localparam int unsigned STS_W        = 8;
    localparam int unsigned STS_PEN_BIT  = 7;
    localparam int unsigned STS_BP_HI    = 3;
    localparam int unsigned STS_BP_LO    = 2;
    localparam int unsigned STS_WEL_BIT  = 1;
    localparam int unsigned STS_BUSY_BIT = 0;

endpackage

// File: rtl/wp_region_guard.sv
module wp_region_guard
    import wpsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              blocked
);

    localparam int unsigned TOP = ADDR_W - 1;

    logic in_upper_half;
    logic in_upper_quarter;

    assign in_upper_half    = addr[TOP];
    assign in_upper_quarter = addr[TOP] & addr[TOP-1];

    always_comb begin
        unique case (prot_t'(bp))
            PROT_NONE:    blocked = 1'b0;
            PROT_QUARTER: blocked = in_upper_quarter;
            PROT_HALF:    blocked = in_upper_half;
            PROT_ALL:     blocked = 1'b1;
            default:      blocked = 1'b1;
        endcase
    end

endmodule

// File: rtl/wp_cycle_timer.sv
module wp_cycle_timer #(
    parameter int unsigned CYC_LEN = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic done
);

    localparam int unsigned CW = (CYC_LEN < 2) ? 1 : $clog2(CYC_LEN);
    localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);

    logic [CW-1:0] cnt;

    assign done = running && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (!running) begin
            if (start) begin
                cnt     <= '0;
                running <= 1'b1;
            end
        end else if (done) begin
            running <= 1'b0;
            cnt     <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wp_status_fsm.sv
module wp_status_fsm
    import wpsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wren,
    input  logic       cmd_wrdi,
    input  logic       cmd_wrsr,
    input  logic [7:0] wrsr_data,
    input  logic       cmd_commit,
    input  logic       addr_blocked,
    input  logic       wp_n,
    input  logic       tmr_done,
    output logic       tmr_start,
    output wp_state_t  state,
    output logic       wel,
    output logic       pen,
    output logic [1:0] bp
);

    wp_state_t  state_nx;
    logic       idle;
    logic       pin_locked;
    logic       take_commit;
    logic       take_wrsr;
    logic       pend_pen;
    logic [1:0] pend_bp;

    assign idle        = (state == ST_IDLE);
    assign pin_locked  = pen && !wp_n;
    assign take_commit = idle && cmd_commit && wel && !addr_blocked;
    assign take_wrsr   = idle && cmd_wrsr && wel && !pin_locked && !take_commit;
    assign tmr_start   = take_commit || take_wrsr;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_commit)    state_nx = ST_ARRAY_PROG;
                else if (take_wrsr) state_nx = ST_STATUS_PROG;
            end
            ST_ARRAY_PROG:  if (tmr_done) state_nx = ST_IDLE;
            ST_STATUS_PROG: if (tmr_done) state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel      <= 1'b0;
            pen      <= 1'b0;
            bp       <= 2'b00;
            pend_pen <= 1'b0;
            pend_bp  <= 2'b00;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take_wrsr) begin
                        pend_pen <= wrsr_data[STS_PEN_BIT];
                        pend_bp  <= wrsr_data[STS_BP_HI:STS_BP_LO];
                    end else if (!take_commit) begin
                        if (cmd_wren)      wel <= 1'b1;
                        else if (cmd_wrdi) wel <= 1'b0;
                    end
                end
                ST_ARRAY_PROG: begin
                    if (tmr_done) wel <= 1'b0;
                end
                ST_STATUS_PROG: begin
                    if (tmr_done) begin
                        wel <= 1'b0;
                        pen <= pend_pen;
                        bp  <= pend_bp;
                    end
                end
                default: wel <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wpsr_ctrl.sv
module wpsr_ctrl
    import wpsr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned CYC_LEN = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_commit,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic              wp_n,
    output logic [7:0]        status_o,
    output logic              wr_allowed_o,
    output logic              busy_o,
    output logic              array_rd_ok_o
);

    wp_state_t  state;
    logic       wel;
    logic       pen;
    logic [1:0] bp;
    logic       blocked;
    logic       tmr_start;
    logic       tmr_done;
    logic       tmr_running;
    logic       unused_bits;

    assign unused_bits = ^{wrsr_data[6:4], wrsr_data[1:0], tmr_running};

    wp_region_guard #(.ADDR_W(ADDR_W)) u_guard (
        .bp      (bp),
        .addr    (commit_addr),
        .blocked (blocked)
    );

    wp_cycle_timer #(.CYC_LEN(CYC_LEN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .running (tmr_running),
        .done    (tmr_done)
    );

    wp_status_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wren     (cmd_wren),
        .cmd_wrdi     (cmd_wrdi),
        .cmd_wrsr     (cmd_wrsr),
        .wrsr_data    (wrsr_data),
        .cmd_commit   (cmd_commit),
        .addr_blocked (blocked),
        .wp_n         (wp_n),
        .tmr_done     (tmr_done),
        .tmr_start    (tmr_start),
        .state        (state),
        .wel          (wel),
        .pen          (pen),
        .bp           (bp)
    );

    always_comb begin
        busy_o        = (state != ST_IDLE);
        array_rd_ok_o = !busy_o;
        wr_allowed_o  = wel && !busy_o && !blocked;
        status_o      = {pen, 3'b000, bp, wel, busy_o};
    end

endmodule

// File: rtl/wpsr_ctrl_chk.sv
module wpsr_ctrl_chk #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned CYC_LEN = 50000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wren,
    input logic              cmd_wrdi,
    input logic              cmd_wrsr,
    input logic [7:0]        wrsr_data,
    input logic              cmd_commit,
    input logic [ADDR_W-1:0] commit_addr,
    input logic              wp_n,
    input logic [7:0]        status_o,
    input logic              wr_allowed_o,
    input logic              busy_o,
    input logic              array_rd_ok_o
);

    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_len <= 0;
        else if (busy_o) busy_len <= busy_len + 1;
        else             busy_len <= 0;
    end

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    p_wren_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wren && !busy_o && !cmd_commit && !cmd_wrsr |=> status_o[1]);

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len == CYC_LEN) && !status_o[1]);

    p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(status_o[1]));

    p_blocked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_commit && !wr_allowed_o && !busy_o && !cmd_wrsr && !cmd_wren |=> !busy_o);

    p_pin_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrsr && status_o[7] && !wp_n && !busy_o && !cmd_commit |=> !busy_o && $stable(status_o));

    p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o || $stable(status_o[7:1]));

    p_rd_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !array_rd_ok_o && !wr_allowed_o);

endmodule

bind wpsr_ctrl wpsr_ctrl_chk #(.ADDR_W(ADDR_W), .CYC_LEN(CYC_LEN)) u_chk (.*);

// File: tb/wpsr_ctrl_bench.sv
module wpsr_ctrl_bench;

    localparam int PERIOD = 10;
    localparam int AW     = 12;
    localparam int CYC    = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_commit = 1'b0;
    logic [7:0]    wrsr_data = 8'h00;
    logic [AW-1:0] commit_addr = '0;
    logic          wp_n = 1'b1;
    logic [7:0]    status_o;
    logic          wr_allowed_o, busy_o, array_rd_ok_o;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    int m_wel = 0, m_pen = 0, m_bp = 0, m_left = 0, m_sts = 0, m_ppen = 0, m_pbp = 0;

    always #(PERIOD/2) clk = ~clk;

    wpsr_ctrl #(.ADDR_W(AW), .CYC_LEN(CYC)) u_wpsr_ctrl (
        .clk, .rst_n, .cmd_wren, .cmd_wrdi, .cmd_wrsr, .wrsr_data,
        .cmd_commit, .commit_addr, .wp_n,
        .status_o, .wr_allowed_o, .busy_o, .array_rd_ok_o
    );

    function automatic int prot(input int bp, input int a);
        case (bp)
            0:       return 0;
            1:       return (a >= 'hC00) ? 1 : 0;
            2:       return (a >= 'h800) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // reference model, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel = 0; m_pen = 0; m_bp = 0; m_left = 0; m_sts = 0;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                m_wel = 0;
                if (m_sts != 0) begin m_pen = m_ppen; m_bp = m_pbp; end
            end
        end else if (cmd_commit && m_wel == 1 && prot(m_bp, int'(commit_addr)) == 0) begin
            m_left = CYC; m_sts = 0;
        end else if (cmd_wrsr && m_wel == 1 && !(m_pen == 1 && !wp_n)) begin
            m_left = CYC; m_sts = 1;
            m_ppen = int'(wrsr_data[7]); m_pbp = int'(wrsr_data[3:2]);
        end else if (cmd_wren) m_wel = 1;
        else if (cmd_wrdi) m_wel = 0;
    end

    // per-clock comparison a quarter period after the edge
    always @(posedge clk) begin
        #(PERIOD/4);
        if (rst_n && !ended) begin
            chk("R2 wel",    int'(status_o[1]),   m_wel);
            chk("R3 wip",    int'(status_o[0]),   (m_left > 0) ? 1 : 0);
            chk("R6 nvbits", int'(status_o[7]) * 16 + int'(status_o[3:2]), m_pen * 16 + m_bp);
            chk("R10 unused", int'(status_o[6:4]), 0);
            chk("R5 allowed", int'(wr_allowed_o),
                (m_wel == 1 && m_left == 0 && prot(m_bp, int'(commit_addr)) == 0) ? 1 : 0);
            chk("R9 rdok",   int'(array_rd_ok_o), (m_left == 0) ? 1 : 0);
        end
    end

    // one strobe for one cycle: 0 wren, 1 wrdi, 2 wrsr, 3 commit
    task automatic cmd(input int k, input logic [7:0] d);
        @(negedge clk);
        wrsr_data  = d;
        cmd_wren   = (k == 0);
        cmd_wrdi   = (k == 1);
        cmd_wrsr   = (k == 2);
        cmd_commit = (k == 3);
        @(negedge clk);
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_commit = 0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int blen;
        repeat (3) @(negedge clk);
        chk("R1 status", int'(status_o), 'h00);
        chk("R1 busy", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 allowed", int'(wr_allowed_o), 0);

        cmd(0, 8'h00); chk("R2 set", int'(status_o), 'h02);
        cmd(1, 8'h00); chk("R2 clear", int'(status_o), 'h00);

        commit_addr = 'h123;
        cmd(3, 8'h00); chk("R4 no wel", int'(busy_o), 0);

        cmd(0, 8'h00);
        cmd(3, 8'h00);
        blen = 0;
        while (busy_o) begin blen++; @(negedge clk); end
        chk("R3 length", blen, CYC);
        chk("R3 wel cleared", int'(status_o), 'h00);

        cmd(0, 8'h00); cmd(2, 8'hFF); wait_idle();
        chk("R6 applied", int'(status_o), 'h8C);

        cmd(0, 8'h00); commit_addr = 'h000;
        cmd(3, 8'h00);
        chk("R4 protected", int'(busy_o), 0);
        chk("R5 all", int'(status_o), 'h8E);

        wp_n = 1'b0;
        cmd(2, 8'h00);
        chk("R7 locked busy", int'(busy_o), 0);
        chk("R7 locked sts", int'(status_o), 'h8E);

        wp_n = 1'b1;
        cmd(2, 8'h04);
        @(negedge clk); wp_n = 1'b0;
        wait_idle();
        chk("R8 applied", int'(status_o), 'h04);

        cmd(0, 8'h00); cmd(2, 8'h08); wait_idle();
        chk("R7 pin ignored", int'(status_o), 'h08);

        cmd(0, 8'h00);
        commit_addr = 'h800; @(negedge clk);
        chk("R5 half top", int'(wr_allowed_o), 0);
        commit_addr = 'h7FF; @(negedge clk);
        chk("R5 half low", int'(wr_allowed_o), 1);
        cmd(3, 8'h00);
        chk("R9 rd blocked", int'(array_rd_ok_o), 0);
        cmd(1, 8'h00); cmd(0, 8'h00); cmd(2, 8'h8C);
        wait_idle();
        chk("R9 ignored", int'(status_o), 'h08);

        cmd(0, 8'h00); cmd(2, 8'h04); wait_idle();
        cmd(0, 8'h00);
        commit_addr = 'hC00; @(negedge clk);
        chk("R5 quarter top", int'(wr_allowed_o), 0);
        commit_addr = 'hBFF; @(negedge clk);
        chk("R5 quarter low", int'(wr_allowed_o), 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule